// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block turns a byte-wide command stream from a host link into accesses on an internal 8-bit register space of 256 addresses. Every command byte has an opcode in its upper nibble and a 4-bit payload in its lower nibble. Two commands build the register address, one for each nibble. Two more build a write byte: one holds the low data nibble, and the next supplies the high nibble and commits the byte. Read commands return one byte each on a return stream with a valid/ready handshake. A read variant can advance the address afterwards, and that advance stays inside the current 16-register page.

Two registers live inside the block: a read-only identification register and a scratch register for link tests. Every other address is served by the surrounding chip. For those addresses the block drives a one-cycle write strobe with address and data, and takes combinational read data for the current address. While a read byte is waiting on the return stream, command intake stops. Because of this, a host can pack many writes and reads into one burst and receive the read bytes in command order.

Top module: `nibreg_cmd_decoder`

## Requirements
- R1: Reset clears the address to 0x00 and the held data-low nibble to 0x0, and empties the return stream. After reset, cmd_ready is 1 and rsp_valid is 0. A first read returns the register at 0x00, and a first commit writes a byte whose low nibble is 0.
- R2: Opcode 0x0 loads address bits 3:0 from the payload and opcode 0x1 loads address bits 7:4. Each leaves the other nibble unchanged. The current address is always visible on ext_addr.
- R3: Opcode 0x2 holds the payload as the low data nibble. Opcode 0x3 commits the byte {payload, held nibble} to the addressed register. For addresses other than the two local registers, this raises ext_we for exactly one cycle, with ext_addr and ext_wdata valid in that cycle.
- R4: Opcode 0x4 (read) and opcode 0x5 (read with increment) each place exactly one byte on the return stream: the addressed register's content at the time the command is accepted. rsp_valid and rsp_byte hold steady until rsp_ready is seen.
- R5: Opcode 0x5 advances the address by one in its low nibble only. It wraps 0xF to 0x0 and keeps bits 7:4. Opcode 0x4 leaves the address unchanged.
- R6: Address 0x00 is a read-only identification register that reads 0xA6. A commit to it changes nothing and raises no ext_we.
- R7: Address 0x0F is a local scratch register. It reads back the last byte committed to it, 0x55 and 0xAA included, and resets to 0x00. A commit to it raises no ext_we.
- R8: When writes and reads are packed back to back, the return stream carries the read results in command order, and each read reflects every earlier write.
- R9: While a byte is pending on the return stream, cmd_ready is 0 and no command is consumed. Intake resumes once the byte is accepted.
- R10: Opcodes 0x6 to 0xF are consumed with no effect. The address, the held data nibble, ext_we and the return stream are all unchanged.
- R11: The held data-low nibble persists across commits. A second opcode 0x3 without a new opcode 0x2 reuses the same low nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_byte | input | 8 | Opcode in bits 7:4, payload in bits 3:0 |
| rsp_valid | output | 1 | Read byte pending on return stream |
| rsp_ready | input | 1 | Return stream consumer accepts the byte |
| rsp_byte | output | 8 | Read result |
| ext_we | output | 1 | One-cycle write strobe for non-local registers |
| ext_addr | output | 8 | Current register address |
| ext_wdata | output | 8 | Write byte, valid with ext_we |
| ext_rdata | input | 8 | Read data of the register at ext_addr |

## Verification
The bench sweeps all 256 addresses and all 256 write bytes against an arithmetic model of the external registers. An address decoder with swapped or merged nibbles would return the wrong model byte, and a data path that dropped the held nibble would show a wrong ext_wdata. The increment tests cross 0xF in two pages. A design that carries into bit 4 would land in the next page, and the page-zero wrap would miss the identification register. A separate test holds the return stream off while a command waits. A design that kept taking commands would change ext_addr early or overwrite the pending byte. The bench also sends every unused opcode with every payload, and a sloppy decoder would let those move the address, strobe a write or answer a read.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

   localparam int unsigned NRD_OPC_W = 4;

   localparam logic [NRD_OPC_W-1:0] OPC_ADDR_LO  = 4'h0;
   localparam logic [NRD_OPC_W-1:0] OPC_ADDR_HI  = 4'h1;
   localparam logic [NRD_OPC_W-1:0] OPC_DATA_LO  = 4'h2;
   localparam logic [NRD_OPC_W-1:0] OPC_COMMIT   = 4'h3;
   localparam logic [NRD_OPC_W-1:0] OPC_READ     = 4'h4;
   localparam logic [NRD_OPC_W-1:0] OPC_READ_INC = 4'h5;

   typedef struct packed {
      logic set_alo;
      logic set_ahi;
      logic set_dlo;
      logic commit;
      logic read;
      logic bump;
   } nrd_dec_t;

endpackage

// File: rtl/nrd_decode.sv
module nrd_decode
   import nrd_pkg::*;
#(
   parameter int unsigned NIB_W = 4
) (
   input  logic                 fire,
   input  logic [NRD_OPC_W-1:0] opcode,
   output nrd_dec_t             dec
);

   always_comb begin
      dec = '0;
      if (fire) begin
         unique case (opcode)
            OPC_ADDR_LO:  dec.set_alo = 1'b1;
            OPC_ADDR_HI:  dec.set_ahi = 1'b1;
            OPC_DATA_LO:  dec.set_dlo = 1'b1;
            OPC_COMMIT:   dec.commit  = 1'b1;
            OPC_READ:     dec.read    = 1'b1;
            OPC_READ_INC: begin
               dec.read = 1'b1;
               dec.bump = 1'b1;
            end
            default:      dec = '0;
         endcase
      end
   end

endmodule

// File: rtl/nrd_addr_hold.sv
module nrd_addr_hold
   import nrd_pkg::*;
#(
   parameter int unsigned NIB_W        = 4,
   parameter bit          WRAP_IN_PAGE = 1'b1,
   localparam int unsigned ADDR_W      = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  nrd_dec_t          dec,
   input  logic [NIB_W-1:0]  payload,
   output logic [ADDR_W-1:0] addr,
   output logic [NIB_W-1:0]  dlo
);

   logic [ADDR_W-1:0] addr_next_inc;

   generate
      if (WRAP_IN_PAGE) begin : g_page_wrap
         assign addr_next_inc = {addr[ADDR_W-1:NIB_W], addr[NIB_W-1:0] + NIB_W'(1)};
      end else begin : g_full_carry
         assign addr_next_inc = addr + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         dlo  <= '0;
      end else begin
         if (dec.set_alo) addr[NIB_W-1:0]      <= payload;
         if (dec.set_ahi) addr[ADDR_W-1:NIB_W] <= payload;
         if (dec.bump)    addr                 <= addr_next_inc;
         if (dec.set_dlo) dlo                  <= payload;
      end
   end

endmodule

// File: rtl/nrd_local_bank.sv
module nrd_local_bank #(
   parameter int unsigned  ADDR_W     = 8,
   parameter int unsigned  DATA_W     = 8,
   parameter int unsigned  ID_ADDR    = 0,
   parameter int unsigned  ID_VALUE   = 8'hA6,
   parameter int unsigned  TEST_ADDR  = 8'h0F,
   parameter int unsigned  TEST_RESET = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              hit_local,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_ADDR);
   localparam logic [ADDR_W-1:0] TEST_A = ADDR_W'(TEST_ADDR);

   logic [DATA_W-1:0] scratch_q;
   logic              hit_id;
   logic              hit_test;

   assign hit_id    = (addr == ID_A);
   assign hit_test  = (addr == TEST_A);
   assign hit_local = hit_id | hit_test;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scratch_q <= DATA_W'(TEST_RESET);
      end else if (commit && hit_test) begin
         scratch_q <= wdata;
      end
   end

   always_comb begin
      if (hit_id)        rdata = DATA_W'(ID_VALUE);
      else if (hit_test) rdata = scratch_q;
      else               rdata = ext_rdata;
   end

endmodule

// File: rtl/nrd_ret_buf.sv
module nrd_ret_buf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rsp_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_byte
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_byte  <= '0;
      end else if (load) begin
         rsp_valid <= 1'b1;
         rsp_byte  <= load_data;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/nibreg_cmd_decoder.sv
module nibreg_cmd_decoder
   import nrd_pkg::*;
#(
   parameter int unsigned NIB_W        = 4,
   parameter int unsigned ID_ADDR      = 0,
   parameter int unsigned ID_VALUE     = 8'hA6,
   parameter int unsigned TEST_ADDR    = 8'h0F,
   parameter int unsigned TEST_RESET   = 0,
   parameter bit          WRAP_IN_PAGE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [7:0] cmd_byte,
   output logic       rsp_valid,
   input  logic       rsp_ready,
   output logic [7:0] rsp_byte,
   output logic       ext_we,
   output logic [7:0] ext_addr,
   output logic [7:0] ext_wdata,
   input  logic [7:0] ext_rdata
);

   localparam int unsigned CMD_W  = 2 * NIB_W;
   localparam int unsigned ADDR_W = 2 * NIB_W;
   localparam int unsigned DATA_W = 2 * NIB_W;

   generate
      if (CMD_W != 8) begin : g_bad_width
         $error("command byte must be 8 bits: NIB_W must be 4");
      end
      if (NRD_OPC_W != CMD_W - NIB_W) begin : g_bad_opc
         $error("opcode field width does not match the upper nibble");
      end
      if (ID_ADDR == TEST_ADDR) begin : g_bad_map
         $error("identification and scratch registers share one address");
      end
      if (ID_ADDR >= (1 << ADDR_W) || TEST_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("local register address outside the address space");
      end
   endgenerate

   logic                 fire;
   nrd_dec_t             dec;
   logic [NIB_W-1:0]     payload;
   logic [NRD_OPC_W-1:0] opcode;
   logic [ADDR_W-1:0]    addr_q;
   logic [NIB_W-1:0]     dlo_q;
   logic [DATA_W-1:0]    wbyte;
   logic                 hit_local;
   logic [DATA_W-1:0]    rd_mux;

   assign cmd_ready = ~rsp_valid;
   assign fire      = cmd_valid & cmd_ready;
   assign payload   = cmd_byte[NIB_W-1:0];
   assign opcode    = cmd_byte[CMD_W-1:NIB_W];
   assign wbyte     = {payload, dlo_q};

   nrd_decode #(.NIB_W(NIB_W)) u_dec (
      .fire   (fire),
      .opcode (opcode),
      .dec    (dec)
   );

   nrd_addr_hold #(.NIB_W(NIB_W), .WRAP_IN_PAGE(WRAP_IN_PAGE)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec     (dec),
      .payload (payload),
      .addr    (addr_q),
      .dlo     (dlo_q)
   );

   nrd_local_bank #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ID_ADDR    (ID_ADDR),
      .ID_VALUE   (ID_VALUE),
      .TEST_ADDR  (TEST_ADDR),
      .TEST_RESET (TEST_RESET)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr_q),
      .wdata     (wbyte),
      .commit    (dec.commit),
      .ext_rdata (ext_rdata),
      .hit_local (hit_local),
      .rdata     (rd_mux)
   );

   nrd_ret_buf #(.DATA_W(DATA_W)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (dec.read),
      .load_data (rd_mux),
      .rsp_ready (rsp_ready),
      .rsp_valid (rsp_valid),
      .rsp_byte  (rsp_byte)
   );

   assign ext_we    = dec.commit & ~hit_local;
   assign ext_addr  = addr_q;
   assign ext_wdata = wbyte;

endmodule

// File: rtl/nrd_chk.sv
module nrd_chk #(
   parameter int unsigned ID_ADDR      = 0,
   parameter int unsigned TEST_ADDR    = 8'h0F,
   parameter bit          WRAP_IN_PAGE = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [7:0] cmd_byte,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic [7:0] rsp_byte,
   input logic       ext_we,
   input logic [7:0] ext_addr
);

   logic acc;
   assign acc = cmd_valid & cmd_ready;

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_byte)); // R4

   AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (cmd_byte[7:4] == 4'h4 || cmd_byte[7:4] == 4'h5) |=> rsp_valid); // R4

   AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> !cmd_ready); // R9

   AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      WRAP_IN_PAGE && acc && cmd_byte[7:4] == 4'h5 |=>
      ext_addr == {$past(ext_addr[7:4]), $past(ext_addr[3:0]) + 4'h1}); // R5

   AST_PLAIN_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_byte[7:4] == 4'h4 |=> $stable(ext_addr)); // R5

   AST_NO_LOCAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_we |-> ext_addr != 8'(ID_ADDR) && ext_addr != 8'(TEST_ADDR)); // R6

   AST_UNUSED_OPC: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_byte[7:4] > 4'h5 |=> $stable(ext_addr) && !rsp_valid); // R10

   AST_STROBE_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      ext_we |-> acc); // R3

endmodule

bind nibreg_cmd_decoder nrd_chk #(
   .ID_ADDR      (ID_ADDR),
   .TEST_ADDR    (TEST_ADDR),
   .WRAP_IN_PAGE (WRAP_IN_PAGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_byte  (cmd_byte),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_byte  (rsp_byte),
   .ext_we    (ext_we),
   .ext_addr  (ext_addr)
);

// File: tb/sim_nibreg_cmd_decoder.sv
module sim_nibreg_cmd_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [7:0] cmd_byte = 8'h00;
   logic       rsp_valid;
   logic       rsp_ready = 1'b1;
   logic [7:0] rsp_byte;
   logic       ext_we;
   logic [7:0] ext_addr;
   logic [7:0] ext_wdata;
   logic [7:0] ext_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] rx [0:1023];
   int         rx_n = 0;
   int         we_n = 0;
   logic [7:0] we_a = 8'h00;
   logic [7:0] we_d = 8'h00;
   logic [7:0] scratch_m = 8'h00;

   always #4 clk = ~clk;

   assign ext_rdata = ext_addr ^ 8'h5A;

   nibreg_cmd_decoder u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_byte  (cmd_byte),
      .rsp_valid (rsp_valid),
      .rsp_ready (rsp_ready),
      .rsp_byte  (rsp_byte),
      .ext_we    (ext_we),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .ext_rdata (ext_rdata)
   );

   always @(posedge clk) begin
      if (rst_n && rsp_valid && rsp_ready && rx_n < 1024) begin
         rx[rx_n] <= rsp_byte;
         rx_n     <= rx_n + 1;
      end
      if (rst_n && ext_we) begin
         we_n <= we_n + 1;
         we_a <= ext_addr;
         we_d <= ext_wdata;
      end
   end

   function automatic logic [7:0] model(input logic [7:0] a);
      if (a == 8'h00)      return 8'hA6;
      else if (a == 8'h0F) return scratch_m;
      else                 return a ^ 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = b;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] a);
      send({4'h0, a[3:0]});
      send({4'h1, a[7:4]});
   endtask

   task automatic wr(input logic [7:0] d);
      send({4'h2, d[3:0]});
      send({4'h3, d[7:4]});
   endtask

   task automatic rd(input logic [7:0] op, input logic [7:0] exp, input string tag);
      int old;
      old = rx_n;
      send(op);
      while (rx_n == old) @(negedge clk);
      chk(rx[old] == exp, tag, rx[old], exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n0;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
      chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
      chk(ext_addr == 8'h00, "R1 addr", ext_addr, 0);
      rd(8'h40, 8'hA6, "R1 R6 first read");
      // R1 data-low cleared: commit without data-low command
      set_addr(8'h20);
      n0 = we_n;
      send(8'h3C);
      @(negedge clk);
      chk(we_n == n0 + 1 && we_d == 8'hC0, "R1 data low reset", we_d, 8'hC0);

      // R2 sweep over all addresses, R4 read of each
      for (int a = 0; a < 256; a++) begin
         set_addr(8'(a));
         @(negedge clk);
         chk(ext_addr == 8'(a), "R2 addr sweep", ext_addr, a);
         rd(8'h40, model(8'(a)), "R4 read sweep");
      end
      set_addr(8'hA3);
      send(8'h07);
      @(negedge clk);
      chk(ext_addr == 8'hA7, "R2 low only", ext_addr, 8'hA7);
      send(8'h1C);
      @(negedge clk);
      chk(ext_addr == 8'hC7, "R2 high only", ext_addr, 8'hC7);

      // R3 every write byte to one external address
      set_addr(8'h37);
      for (int d = 0; d < 256; d++) begin
         n0 = we_n;
         wr(8'(d));
         @(negedge clk);
         chk(we_n == n0 + 1, "R3 one strobe", we_n - n0, 1);
         chk(we_a == 8'h37 && we_d == 8'(d), "R3 strobe data", {we_a, we_d}, {8'h37, 8'(d)});
      end

      // R7 scratch register
      set_addr(8'h0F);
      n0 = we_n;
      wr(8'h55); scratch_m = 8'h55;
      rd(8'h40, 8'h55, "R7 scratch 55");
      wr(8'hAA); scratch_m = 8'hAA;
      rd(8'h40, 8'hAA, "R7 scratch AA");
      chk(we_n == n0, "R7 no strobe", we_n - n0, 0);

      // R6 ID write ignored
      set_addr(8'h00);
      n0 = we_n;
      wr(8'h12);
      rd(8'h40, 8'hA6, "R6 id read only");
      chk(we_n == n0, "R6 no strobe", we_n - n0, 0);

      // R5 increment wrap inside page
      set_addr(8'h3D);
      rd(8'h40, model(8'h3D), "R5 plain read");
      rd(8'h40, model(8'h3D), "R5 plain read keeps addr");
      for (int k = 0; k < 4; k++) begin
         logic [7:0] ea;
         ea = {4'h3, 4'(4'hD + k)};
         rd(8'h50, model(ea), "R5 inc read");
      end
      @(negedge clk);
      chk(ext_addr == 8'h31, "R5 wrap addr", ext_addr, 8'h31);
      set_addr(8'h0E);
      rd(8'h50, model(8'h0E), "R5 page0 e");
      rd(8'h50, scratch_m, "R5 page0 f");
      rd(8'h50, 8'hA6, "R5 page0 wrap id");

      // R8 packed burst: writes and reads in order
      set_addr(8'h0F);
      n0 = rx_n;
      wr(8'h3C);
      send(8'h40);
      wr(8'hC3);
      send(8'h40);
      send(8'h00);
      send(8'h40);
      repeat (4) @(negedge clk);
      scratch_m = 8'hC3;
      chk(rx_n == n0 + 3, "R8 count", rx_n - n0, 3);
      chk(rx[n0] == 8'h3C, "R8 first", rx[n0], 8'h3C);
      chk(rx[n0+1] == 8'hC3, "R8 second", rx[n0+1], 8'hC3);
      chk(rx[n0+2] == 8'hA6, "R8 third", rx[n0+2], 8'hA6);

      // R9 stall while return byte pending
      set_addr(8'h44);
      rsp_ready = 1'b0;
      n0 = rx_n;
      send(8'h40);
      @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_byte == 8'h1E, "R9 pending byte", rsp_byte, 8'h1E);
      chk(cmd_ready == 1'b0, "R9 cmd_ready low", cmd_ready, 0);
      fork
         send(8'h0B);
      join_none
      repeat (6) @(negedge clk);
      chk(ext_addr == 8'h44, "R9 no intake", ext_addr, 8'h44);
      chk(rsp_valid == 1'b1 && rsp_byte == 8'h1E, "R4 byte held", rsp_byte, 8'h1E);
      rsp_ready = 1'b1;
      wait fork;
      @(negedge clk);
      chk(ext_addr == 8'h4B, "R9 resumed", ext_addr, 8'h4B);
      chk(rx_n == n0 + 1 && rx[n0] == 8'h1E, "R9 byte delivered", rx[n0], 8'h1E);

      // R10 unused opcodes, all payloads
      set_addr(8'h25);
      send(8'h29);
      n0 = we_n;
      held = 8'(rx_n);
      for (int op = 6; op < 16; op++) begin
         for (int p = 0; p < 16; p++) begin
            send({4'(op), 4'(p)});
         end
      end
      repeat (3) @(negedge clk);
      chk(ext_addr == 8'h25, "R10 addr kept", ext_addr, 8'h25);
      chk(we_n == n0, "R10 no strobe", we_n - n0, 0);
      chk(8'(rx_n) == held, "R10 no response", rx_n, held);
      send(8'h34);
      @(negedge clk);
      chk(we_d == 8'h49 && we_a == 8'h25, "R10 R11 data low kept", we_d, 8'h49);
      // R11 reuse held nibble
      send(8'h37);
      @(negedge clk);
      chk(we_d == 8'h79, "R11 second commit", we_d, 8'h79);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule